// File: doc/BRIEF.md
# Line activity and status monitor

This block watches a received serial bit stream for signs of line activity and keeps an 8-bit status word for a host to read. Received bits are accepted only in cycles where the bit-clock enable is high. The live activity flag rises once three zero bits fall inside any span of 48 accepted bits. It drops only after 128 accepted one bits in a row.

Other results come from outside logic: frame synchronization, the two-bit activation state, and D-channel access events (opening flag sent, closing flag of the last queued packet sent, collision, priority restored). The block folds these into the status word. One status bit is shared. While activation is requested and deactivation is not, it reports frame synchronization. In every other case it reports line activity.

The status word is captured only on the frame strobe, so every host read within one frame returns the same value. A read strobe returns the captured word one cycle later, together with a one-cycle valid pulse. This read path has no back-pressure: the consumer must take the word in the cycle in which the valid pulse is high, because the word is not held for it.

Top module: `lsm_monitor`

## Requirements
- R1: When `rx_bit_en` is high and `rx_bit` is the third zero among the last 48 accepted bits (the current bit included), `line_active` is 1 from the next cycle on. Cycles with `rx_bit_en` low change nothing.
- R2: Zeros that are 48 accepted bits apart never count together. For example, zeros at accepted bits 0, 24 and 48 leave `line_active` at 0.
- R3: `line_active` clears in the cycle after the 128th consecutive accepted one. It stays at 1 after 127 ones, and an accepted zero never clears it.
- R4: Status bit 7 equals `frame_sync` when `act_req`=1 and `deact_req`=0. Otherwise it equals the activity flag.
- R5: Status bits 6:5 carry `act_state`, encoded 00 deactivated, 01 synchronized, 10 activation request, 11 activated.
- R6: A `dch_open` pulse sets the access bit (status bit 4) from the next cycle.
- R7: A `dch_last_close` pulse clears both the access bit and the priority bit (status bit 3). A `prio_raise` pulse sets the priority bit, but `dch_last_close` wins if both arrive in the same cycle.
- R8: A `dch_collision` pulse clears the access bit and wins over a simultaneous `dch_open`.
- R9: The status word {bit7 sync/activity, bits6:5 state, bit4 access, bit3 priority, bit2 activity flag, bits1:0 zero} is captured only in `frame_stb` cycles. A read issued in the same cycle as `frame_stb` returns the previous capture.
- R10: `rd_valid` is high, and `rd_data` holds the captured word, exactly in the cycle after `rd_stb`. At all other times `rd_valid` is low.
- R11: A synchronous active-high `rst` clears the activity flag, the bit history, the access bit, the priority bit, the captured word and the read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received bit |
| rx_bit_en | input | 1 | Bit-clock enable; `rx_bit` is accepted when high |
| frame_stb | input | 1 | Frame strobe; captures the status word |
| act_req | input | 1 | Activation request |
| deact_req | input | 1 | Deactivation request |
| frame_sync | input | 1 | Frame synchronization achieved |
| act_state | input | 2 | Activation state code |
| dch_open | input | 1 | Pulse: access gained, opening flag sent |
| dch_last_close | input | 1 | Pulse: closing flag of last queued packet sent |
| dch_collision | input | 1 | Pulse: collision during transmission |
| prio_raise | input | 1 | Pulse: priority restored to high |
| rd_stb | input | 1 | Host read strobe |
| line_active | output | 1 | Live activity flag |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_stb` |
| rd_data | output | 8 | Captured status word |

## Verification
The window edge gets two tests. Zeros at accepted bits 0, 24 and 47 must set the flag, while zeros at 0, 24 and 48 must not. A design that gets the window length wrong by one fails one of these two cases. The clear path is tested with runs of exactly 127 ones and exactly 128 ones, with a zero placed between them; an off-by-one threshold, or a design that clears on a zero, is caught here. Other directed cases cover reading in the same cycle as the frame strobe (a design that reads through the capture register returns the new word) and the clear-wins events (collision with open, close with raise). A vector table also walks the sync/activity bit through all four request combinations.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int STATE_W = 2;
  localparam int WORD_W  = 8;

  typedef struct packed {
    logic               sync_act;
    logic [STATE_W-1:0] state;
    logic               dch_access;
    logic               prio;
    logic               active;
    logic [1:0]         rsvd;
  } status_t;
endpackage

// File: rtl/lsm_activity_det.sv
module lsm_activity_det #(
  parameter int WIN_LEN     = 48,
  parameter int ZERO_THRESH = 3,
  parameter int ONES_CLEAR  = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_en,
  output logic active
);
  localparam int CNT_W  = $clog2(WIN_LEN + 1);
  localparam int ONES_W = $clog2(ONES_CLEAR + 1);

  logic [WIN_LEN-1:0] zhist_q;
  logic [CNT_W-1:0]   zcnt_q, zcnt_next;
  logic [ONES_W-1:0]  ones_q, ones_next;
  logic               active_q;
  logic               is_zero, set_hit, clr_hit;

  // window holds one flag per accepted bit; oldest flag leaves at the top
  always_comb begin
    is_zero   = ~bit_in;
    zcnt_next = zcnt_q + CNT_W'(is_zero) - CNT_W'(zhist_q[WIN_LEN-1]);
    if (is_zero)
      ones_next = '0;
    else if (ones_q == ONES_W'(ONES_CLEAR))
      ones_next = ones_q;
    else
      ones_next = ones_q + 1'b1;
    set_hit = zcnt_next >= CNT_W'(ZERO_THRESH);
    clr_hit = ones_next == ONES_W'(ONES_CLEAR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zhist_q  <= '0;
      zcnt_q   <= '0;
      ones_q   <= '0;
      active_q <= 1'b0;
    end else if (bit_en) begin
      zhist_q <= {zhist_q[WIN_LEN-2:0], is_zero};
      zcnt_q  <= zcnt_next;
      ones_q  <= ones_next;
      if (set_hit)
        active_q <= 1'b1;
      else if (clr_hit)
        active_q <= 1'b0;
    end
  end

  assign active = active_q;
endmodule

// File: rtl/lsm_dch_ctrl.sv
module lsm_dch_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic open_ev,
  input  logic last_close_ev,
  input  logic collision_ev,
  input  logic prio_raise_ev,
  output logic access,
  output logic prio
);
  logic access_q, prio_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      access_q <= 1'b0;
      prio_q   <= 1'b0;
    end else begin
      if (last_close_ev || collision_ev)
        access_q <= 1'b0;
      else if (open_ev)
        access_q <= 1'b1;

      if (last_close_ev)
        prio_q <= 1'b0;
      else if (prio_raise_ev)
        prio_q <= 1'b1;
    end
  end

  assign access = access_q;
  assign prio   = prio_q;
endmodule

// File: rtl/lsm_status_snap.sv
module lsm_status_snap
  import lsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  status_t           live,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] snap,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] snap_q, rd_data_q;
  logic              rd_valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q     <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (frame_stb)
        snap_q <= live;
      rd_valid_q <= rd_stb;
      if (rd_stb)
        rd_data_q <= snap_q;
    end
  end

  assign snap     = snap_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/lsm_monitor.sv
module lsm_monitor
  import lsm_pkg::*;
#(
  parameter int WIN_LEN     = 48,
  parameter int ZERO_THRESH = 3,
  parameter int ONES_CLEAR  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit,
  input  logic              rx_bit_en,
  input  logic              frame_stb,
  input  logic              act_req,
  input  logic              deact_req,
  input  logic              frame_sync,
  input  logic [STATE_W-1:0] act_state,
  input  logic              dch_open,
  input  logic              dch_last_close,
  input  logic              dch_collision,
  input  logic              prio_raise,
  input  logic              rd_stb,
  output logic              line_active,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  logic              active_w, access_w, prio_w;
  logic [WORD_W-1:0] snap_w;
  status_t           live_w;

  lsm_activity_det #(
    .WIN_LEN(WIN_LEN), .ZERO_THRESH(ZERO_THRESH), .ONES_CLEAR(ONES_CLEAR)
  ) u_act (
    .clk(clk), .rst(rst), .bit_in(rx_bit), .bit_en(rx_bit_en), .active(active_w)
  );

  lsm_dch_ctrl u_dch (
    .clk(clk), .rst(rst),
    .open_ev(dch_open), .last_close_ev(dch_last_close),
    .collision_ev(dch_collision), .prio_raise_ev(prio_raise),
    .access(access_w), .prio(prio_w)
  );

  always_comb begin
    live_w.sync_act   = (act_req && !deact_req) ? frame_sync : active_w;
    live_w.state      = act_state;
    live_w.dch_access = access_w;
    live_w.prio       = prio_w;
    live_w.active     = active_w;
    live_w.rsvd       = 2'b00;
  end

  lsm_status_snap u_snap (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .live(live_w),
    .rd_stb(rd_stb), .snap(snap_w), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign line_active = active_w;
endmodule

// File: rtl/lsm_checker.sv
module lsm_checker (
  input logic       clk,
  input logic       rst,
  input logic       rx_bit,
  input logic       rx_bit_en,
  input logic       frame_stb,
  input logic       act_req,
  input logic       deact_req,
  input logic       frame_sync,
  input logic       dch_open,
  input logic       dch_last_close,
  input logic       dch_collision,
  input logic       rd_stb,
  input logic       line_active,
  input logic       access,
  input logic       prio,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic [7:0] snap
);
  p_idle_bit_r1: assert property (@(posedge clk) disable iff (rst)
    !rx_bit_en |=> $stable(line_active));

  p_zero_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (line_active && rx_bit_en && !rx_bit) |=> line_active);

  p_sync_sel_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && act_req && !deact_req) |=> snap[7] == $past(frame_sync));

  p_open_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (dch_open && !dch_last_close && !dch_collision) |=> access);

  p_close_clears_r7: assert property (@(posedge clk) disable iff (rst)
    dch_last_close |=> (!access && !prio));

  p_collision_r8: assert property (@(posedge clk) disable iff (rst)
    dch_collision |=> !access);

  p_snap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(snap));

  p_rd_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> (rd_valid && rd_data == $past(snap)));

  p_rd_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> !rd_valid);

  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!line_active && !rd_valid && snap == 8'h00 && !access && !prio));
endmodule

bind lsm_monitor lsm_checker u_chk (
  .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_bit_en(rx_bit_en),
  .frame_stb(frame_stb), .act_req(act_req), .deact_req(deact_req),
  .frame_sync(frame_sync), .dch_open(dch_open), .dch_last_close(dch_last_close),
  .dch_collision(dch_collision), .rd_stb(rd_stb), .line_active(line_active),
  .access(access_w), .prio(prio_w), .rd_valid(rd_valid), .rd_data(rd_data),
  .snap(snap_w)
);

// File: tb/lsm_monitor_test.sv
module lsm_monitor_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b1, rx_bit_en = 1'b0, frame_stb = 1'b0;
  logic       act_req = 1'b0, deact_req = 1'b0, frame_sync = 1'b0;
  logic [1:0] act_state = 2'b00;
  logic       dch_open = 1'b0, dch_last_close = 1'b0, dch_collision = 1'b0;
  logic       prio_raise = 1'b0, rd_stb = 1'b0;
  logic       line_active, rd_valid;
  logic [7:0] rd_data;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  lsm_monitor uut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_bit_en(rx_bit_en),
    .frame_stb(frame_stb), .act_req(act_req), .deact_req(deact_req),
    .frame_sync(frame_sync), .act_state(act_state), .dch_open(dch_open),
    .dch_last_close(dch_last_close), .dch_collision(dch_collision),
    .prio_raise(prio_raise), .rd_stb(rd_stb), .line_active(line_active),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // {act_req, deact_req, frame_sync, act_state[1:0], open, close, coll, raise, expected word}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b1, 2'b00, 4'b0000, 8'h00},
    {1'b1, 1'b0, 1'b1, 2'b01, 4'b1000, 8'hB0},
    {1'b1, 1'b1, 1'b1, 2'b10, 4'b0001, 8'h58},
    {1'b1, 1'b0, 1'b0, 2'b11, 4'b0010, 8'h68},
    {1'b1, 1'b0, 1'b1, 2'b11, 4'b1000, 8'hF8},
    {1'b0, 1'b0, 1'b1, 2'b11, 4'b0100, 8'h60},
    {1'b1, 1'b0, 1'b1, 2'b01, 4'b1010, 8'hA0},
    {1'b0, 1'b1, 1'b0, 2'b00, 4'b0101, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_bit = b; rx_bit_en = 1'b1;
    @(negedge clk);
    rx_bit_en = 1'b0; rx_bit = 1'b1;
  endtask

  task automatic pulse_frame();
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic read_word(output logic [7:0] w, output logic v);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    w = rd_data; v = rd_valid;
  endtask

  task automatic pulse_events(input logic [3:0] ev);
    {dch_open, dch_last_close, dch_collision, prio_raise} = ev;
    @(negedge clk);
    {dch_open, dch_last_close, dch_collision, prio_raise} = 4'b0000;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] w;
    logic       v;
    @(negedge clk);
    do_reset();

    // R11 reset state, R10 idle valid
    check("R11 active after reset", {7'd0, line_active}, 8'h00);
    check("R10 valid idle", {7'd0, rd_valid}, 8'h00);
    read_word(w, v);
    check("R10 valid after read", {7'd0, v}, 8'h01);
    check("R11 word after reset", w, 8'h00);
    @(negedge clk);
    check("R10 valid drops", {7'd0, rd_valid}, 8'h00);

    // R1 zeros without enable are ignored
    rx_bit = 1'b0;
    repeat (10) @(negedge clk);
    rx_bit = 1'b1;
    check("R1 ignored when enable low", {7'd0, line_active}, 8'h00);

    // table: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 8; i++) begin
      {act_req, deact_req, frame_sync, act_state} = VEC[i][16:12];
      pulse_events(VEC[i][11:8]);
      pulse_frame();
      read_word(w, v);
      check($sformatf("R4/R5/R6/R7/R8 vector %0d", i), w, VEC[i][7:0]);
    end

    // R2 zeros 48 bits apart
    do_reset();
    for (int i = 0; i < 60; i++) send_bit(!(i == 0 || i == 24 || i == 48));
    check("R2 spread zeros", {7'd0, line_active}, 8'h00);

    // R1 three zeros in 48
    do_reset();
    for (int i = 0; i < 47; i++) send_bit(!(i == 0 || i == 24));
    check("R1 before third zero", {7'd0, line_active}, 8'h00);
    send_bit(1'b0);
    check("R1 third zero sets", {7'd0, line_active}, 8'h01);

    // R4 with activity set
    {act_req, deact_req, frame_sync, act_state} = 5'b00000;
    @(negedge clk);
    pulse_frame(); read_word(w, v);
    check("R4 no request shows activity", w, 8'h84);
    {act_req, deact_req} = 2'b10;
    @(negedge clk);
    pulse_frame(); read_word(w, v);
    check("R4 request shows sync", w, 8'h04);
    {act_req, deact_req} = 2'b11;
    @(negedge clk);
    pulse_frame(); read_word(w, v);
    check("R4 deactivation shows activity", w, 8'h84);

    // R9 hold between frames, same-cycle read
    {act_req, deact_req, frame_sync} = 3'b100;
    @(negedge clk);
    read_word(w, v);
    check("R9 hold between frames", w, 8'h84);
    frame_stb = 1'b1; rd_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0; rd_stb = 1'b0;
    check("R9 read with frame strobe", rd_data, 8'h84);
    read_word(w, v);
    check("R9 next read new word", w, 8'h04);

    // R3 consecutive ones
    for (int i = 0; i < 127; i++) send_bit(1'b1);
    check("R3 127 ones keep", {7'd0, line_active}, 8'h01);
    send_bit(1'b0);
    check("R3 zero keeps", {7'd0, line_active}, 8'h01);
    for (int i = 0; i < 127; i++) send_bit(1'b1);
    check("R3 127 ones again keep", {7'd0, line_active}, 8'h01);
    send_bit(1'b1);
    check("R3 128th one clears", {7'd0, line_active}, 8'h00);

    // R11 mid-run reset
    pulse_events(4'b1001);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    {act_req, deact_req, frame_sync, act_state} = 5'b00011;
    @(negedge clk);
    pulse_frame(); read_word(w, v);
    check("R11 pre-reset word", w, 8'hFC);
    do_reset();
    check("R11 activity cleared", {7'd0, line_active}, 8'h00);
    read_word(w, v);
    check("R11 capture cleared", w, 8'h00);
    act_state = 2'b00;
    @(negedge clk);
    pulse_frame(); read_word(w, v);
    check("R11 access and priority cleared", w, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule